// File: doc/BRIEF.md
# Sharing-List Cache Line Node

This block is the cache-side coherence controller of one node in a system where the sharers of each memory line form a doubly linked list. For each of a small number of local lines it holds a coherence state and two node pointers. The forward pointer names the next sharer further down the list, and the backward pointer names the previous sharer toward the head. The home directory only knows the head of each list. Every other link lives in the caches, so all list maintenance is done by messages exchanged between neighbours.

Incoming messages arrive one per cycle. Each carries a kind, a line index, a source node and a pointer argument. The block updates the addressed line and produces zero to three outgoing messages. It sends them one per cycle, in a fixed order, and holds `in_ready` low until the last one has left. A read fill inserts the node as the new head and notifies the old head. A write fill first unlinks the node if it is already listed, then walks the list one sharer at a time with invalidations. An eviction unlinks the line. A query port reads any line's state and pointers combinationally.

Top module: `share_list_node`

## Requirements
- R1: After reset every line reads Invalid (state code 0), pending flag 0, forward and backward pointers equal to the null value (all ones). `in_ready` is 1 and `out_valid` is 0.
- R2: A read fill (kind 0) whose pointer is null makes the line Exclusive (code 2) with both pointers null, and sends no message.
- R3: A read fill whose pointer names node H makes the line Shared (code 1) with forward pointer H and null backward pointer. Exactly one message is sent, in the cycle after acceptance: an insert (kind 3) to H carrying the node's own ID.
- R4: An insert (kind 3) on a valid line sets the backward pointer to the source node and turns Exclusive or Modified into Shared. On an Invalid line it changes nothing.
- R5: A set-forward (kind 4) or set-backward (kind 5) on a valid line overwrites that pointer with the message pointer. On an Invalid line it changes nothing.
- R6: An invalidate (kind 6) makes the line Invalid with null pointers. It replies with one invalidate-ack (kind 7) to the source, carrying the former forward pointer, or null if the line was already Invalid.
- R7: A write fill (kind 1) with non-null effective head E leaves the line Shared (code 1) with the pending flag set, forward pointer E and null backward pointer. It sends an invalidate (kind 6) to E carrying the node's own ID.
- R8: An invalidate-ack on a pending line with non-null pointer P sets the forward pointer to P and sends an invalidate to P. With a null pointer the line becomes Modified (code 3), not pending, with a null forward pointer. On a line that is not pending it changes nothing.
- R9: A write fill on a line that is already listed first unlinks it. It sends a set-forward (kind 4) to the old backward neighbour carrying the old forward pointer, then a set-backward (kind 5) to the old forward neighbour carrying the old backward pointer, each only when that neighbour is non-null. The invalidate follows last. When the fill's pointer equals the node's own ID, the effective head is the former forward pointer.
- R10: An eviction (kind 2) sends the same unlink messages as R9 and leaves the line Invalid with null pointers.
- R11: Outgoing messages leave one per cycle with no gaps. `in_ready` stays 0 while any are queued, and no message is ever addressed to the null node.
- R12: A write fill whose effective head is null makes the line Modified at once, with null pointers and no invalidation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| msg_valid | input | 1 | Incoming message present |
| in_ready | output | 1 | Block can accept a message this cycle |
| msg_kind | input | 3 | Incoming message kind |
| msg_line | input | LW | Target line index |
| msg_src | input | IDW | Sending node ID |
| msg_ptr | input | IDW | Pointer argument |
| out_valid | output | 1 | Outgoing message present |
| out_kind | output | 3 | Outgoing message kind |
| out_dst | output | IDW | Destination node |
| out_ptr | output | IDW | Pointer argument of outgoing message |
| out_line | output | LW | Line index of outgoing message |
| q_line | input | LW | Line selected for query |
| q_state | output | 2 | State of queried line |
| q_pend | output | 1 | Invalidation walk pending on queried line |
| q_fwd | output | IDW | Forward pointer of queried line |
| q_bck | output | IDW | Backward pointer of queried line |

## Verification
The properties assume that the sender raises `msg_valid` only while `in_ready` is high, and that messages are coherent with the list. An invalidate-ack comes only in answer to this node's own walk, and neighbour updates target lines that are listed. The stimulus follows one consistent list history per line. It waits for `in_ready` to return before each new message. It sends neighbour updates and acks only where a real list would produce them, except for the deliberate ignored-message cases on Invalid or non-pending lines.

// File: rtl/slnode_pkg.sv
package slnode_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} lstate_e;
  typedef enum logic [2:0] {
    K_FILL_RD = 3'd0, K_FILL_WR = 3'd1, K_EVICT = 3'd2, K_INSERT = 3'd3,
    K_SET_FWD = 3'd4, K_SET_BCK = 3'd5, K_INVAL = 3'd6, K_INV_ACK = 3'd7
  } mkind_e;
endpackage

// File: rtl/sln_line_store.sv
module sln_line_store #(
  parameter int NLINES = 4,
  parameter int IDW    = 4,
  parameter int LW     = 2
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic           we,
  input  logic [LW-1:0]  wr_line,
  input  logic [1:0]     wr_st,
  input  logic           wr_pend,
  input  logic [IDW-1:0] wr_f,
  input  logic [IDW-1:0] wr_b,
  input  logic [LW-1:0]  ra_line,
  output logic [1:0]     ra_st,
  output logic           ra_pend,
  output logic [IDW-1:0] ra_f,
  output logic [IDW-1:0] ra_b,
  input  logic [LW-1:0]  rb_line,
  output logic [1:0]     rb_st,
  output logic           rb_pend,
  output logic [IDW-1:0] rb_f,
  output logic [IDW-1:0] rb_b
);
  import slnode_pkg::*;
  localparam logic [IDW-1:0] NULLID = '1;

  logic [NLINES-1:0][1:0]     st_q;
  logic [NLINES-1:0]          pend_q;
  logic [NLINES-1:0][IDW-1:0] f_q;
  logic [NLINES-1:0][IDW-1:0] b_q;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic en;
    assign en = we && (wr_line == LW'(g));
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[g]   <= ST_I;
        pend_q[g] <= 1'b0;
        f_q[g]    <= NULLID;
        b_q[g]    <= NULLID;
      end else if (en) begin
        st_q[g]   <= wr_st;
        pend_q[g] <= wr_pend;
        f_q[g]    <= wr_f;
        b_q[g]    <= wr_b;
      end
    end
  end

  assign ra_st   = st_q[ra_line];
  assign ra_pend = pend_q[ra_line];
  assign ra_f    = f_q[ra_line];
  assign ra_b    = b_q[ra_line];
  assign rb_st   = st_q[rb_line];
  assign rb_pend = pend_q[rb_line];
  assign rb_f    = f_q[rb_line];
  assign rb_b    = b_q[rb_line];
endmodule

// File: rtl/sln_decode.sv
module sln_decode #(
  parameter int IDW   = 4,
  parameter int MY_ID = 3
) (
  input  logic                 in_valid,
  input  logic [2:0]           in_kind,
  input  logic [IDW-1:0]       in_src,
  input  logic [IDW-1:0]       in_ptr,
  input  logic [1:0]           cur_st,
  input  logic                 cur_pend,
  input  logic [IDW-1:0]       cur_f,
  input  logic [IDW-1:0]       cur_b,
  output logic                 wr_en,
  output logic [1:0]           nx_st,
  output logic                 nx_pend,
  output logic [IDW-1:0]       nx_f,
  output logic [IDW-1:0]       nx_b,
  output logic [2:0]           c_v,
  output logic [2:0][2:0]      c_kind,
  output logic [2:0][IDW-1:0]  c_dst,
  output logic [2:0][IDW-1:0]  c_ptr
);
  import slnode_pkg::*;
  localparam logic [IDW-1:0] NULLID = '1;
  localparam logic [IDW-1:0] SELF   = IDW'(MY_ID);

  logic           listed;
  logic [IDW-1:0] head_eff;

  always_comb begin
    listed   = (cur_st != ST_I);
    head_eff = (in_ptr == SELF) ? (listed ? cur_f : NULLID) : in_ptr;
    wr_en    = 1'b0;
    nx_st    = cur_st;
    nx_pend  = cur_pend;
    nx_f     = cur_f;
    nx_b     = cur_b;
    c_v      = '0;
    c_kind   = '0;
    c_dst    = '0;
    c_ptr    = '0;
    if (in_valid) begin
      case (in_kind)
        K_FILL_RD: begin
          wr_en   = 1'b1;
          nx_st   = (in_ptr == NULLID) ? ST_E : ST_S;
          nx_pend = 1'b0;
          nx_f    = in_ptr;
          nx_b    = NULLID;
          if (in_ptr != NULLID) begin
            c_v[2] = 1'b1; c_kind[2] = K_INSERT; c_dst[2] = in_ptr; c_ptr[2] = SELF;
          end
        end
        K_FILL_WR, K_EVICT: begin
          wr_en = 1'b1;
          if (listed && cur_b != NULLID) begin
            c_v[0] = 1'b1; c_kind[0] = K_SET_FWD; c_dst[0] = cur_b; c_ptr[0] = cur_f;
          end
          if (listed && cur_f != NULLID) begin
            c_v[1] = 1'b1; c_kind[1] = K_SET_BCK; c_dst[1] = cur_f; c_ptr[1] = cur_b;
          end
          nx_b = NULLID;
          if (in_kind == K_EVICT) begin
            nx_st = ST_I; nx_pend = 1'b0; nx_f = NULLID;
          end else if (head_eff == NULLID) begin
            nx_st = ST_M; nx_pend = 1'b0; nx_f = NULLID;
          end else begin
            nx_st = ST_S; nx_pend = 1'b1; nx_f = head_eff;
            c_v[2] = 1'b1; c_kind[2] = K_INVAL; c_dst[2] = head_eff; c_ptr[2] = SELF;
          end
        end
        K_INSERT: begin
          if (listed) begin
            wr_en = 1'b1;
            nx_b  = in_src;
            if (cur_st == ST_E || cur_st == ST_M) nx_st = ST_S;
          end
        end
        K_SET_FWD: begin
          if (listed) begin
            wr_en = 1'b1; nx_f = in_ptr;
          end
        end
        K_SET_BCK: begin
          if (listed) begin
            wr_en = 1'b1; nx_b = in_ptr;
          end
        end
        K_INVAL: begin
          wr_en   = 1'b1;
          nx_st   = ST_I;
          nx_pend = 1'b0;
          nx_f    = NULLID;
          nx_b    = NULLID;
          if (in_src != NULLID) begin
            c_v[2] = 1'b1; c_kind[2] = K_INV_ACK; c_dst[2] = in_src;
            c_ptr[2] = listed ? cur_f : NULLID;
          end
        end
        default: begin
          if (cur_pend) begin
            wr_en = 1'b1;
            if (in_ptr == NULLID) begin
              nx_st = ST_M; nx_pend = 1'b0; nx_f = NULLID;
            end else begin
              nx_f   = in_ptr;
              c_v[2] = 1'b1; c_kind[2] = K_INVAL; c_dst[2] = in_ptr; c_ptr[2] = SELF;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sln_outq.sv
module sln_outq #(
  parameter int IDW = 4,
  parameter int LW  = 2,
  parameter int NC  = 3
) (
  input  logic                  clk,
  input  logic                  rst_ni,
  input  logic                  load,
  input  logic [LW-1:0]         ld_line,
  input  logic [NC-1:0]         c_v,
  input  logic [NC-1:0][2:0]    c_kind,
  input  logic [NC-1:0][IDW-1:0] c_dst,
  input  logic [NC-1:0][IDW-1:0] c_ptr,
  output logic                  busy,
  output logic                  o_valid,
  output logic [2:0]            o_kind,
  output logic [IDW-1:0]        o_dst,
  output logic [IDW-1:0]        o_ptr,
  output logic [LW-1:0]         o_line
);
  localparam int CW = $clog2(NC + 1);

  logic [NC-1:0]          v_q, v_n, pk_v;
  logic [NC-1:0][2:0]     k_q, k_n, pk_k;
  logic [NC-1:0][IDW-1:0] d_q, d_n, pk_d;
  logic [NC-1:0][IDW-1:0] p_q, p_n, pk_p;
  logic [LW-1:0]          line_q, line_n;
  logic [CW-1:0]          idx;
  logic                   en;

  always_comb begin
    pk_v = '0; pk_k = '0; pk_d = '0; pk_p = '0; idx = '0;
    for (int i = 0; i < NC; i++) begin
      if (c_v[i]) begin
        pk_v[idx] = 1'b1;
        pk_k[idx] = c_kind[i];
        pk_d[idx] = c_dst[i];
        pk_p[idx] = c_ptr[i];
        idx = idx + CW'(1);
      end
    end
  end

  always_comb begin
    v_n = v_q; k_n = k_q; d_n = d_q; p_n = p_q; line_n = line_q;
    if (load) begin
      v_n = pk_v; k_n = pk_k; d_n = pk_d; p_n = pk_p; line_n = ld_line;
    end else begin
      for (int i = 0; i < NC - 1; i++) begin
        v_n[i] = v_q[i+1]; k_n[i] = k_q[i+1]; d_n[i] = d_q[i+1]; p_n[i] = p_q[i+1];
      end
      v_n[NC-1] = 1'b0;
    end
  end

  assign en = load || v_q[0];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0; k_q <= '0; d_q <= '0; p_q <= '0; line_q <= '0;
    end else if (en) begin
      v_q <= v_n; k_q <= k_n; d_q <= d_n; p_q <= p_n; line_q <= line_n;
    end
  end

  assign busy    = |v_q;
  assign o_valid = v_q[0];
  assign o_kind  = k_q[0];
  assign o_dst   = d_q[0];
  assign o_ptr   = p_q[0];
  assign o_line  = line_q;
endmodule

// File: rtl/share_list_node.sv
module share_list_node #(
  parameter int NLINES = 4,
  parameter int IDW    = 4,
  parameter int MY_ID  = 3,
  localparam int LW    = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           msg_valid,
  output logic           in_ready,
  input  logic [2:0]     msg_kind,
  input  logic [LW-1:0]  msg_line,
  input  logic [IDW-1:0] msg_src,
  input  logic [IDW-1:0] msg_ptr,
  output logic           out_valid,
  output logic [2:0]     out_kind,
  output logic [IDW-1:0] out_dst,
  output logic [IDW-1:0] out_ptr,
  output logic [LW-1:0]  out_line,
  input  logic [LW-1:0]  q_line,
  output logic [1:0]     q_state,
  output logic           q_pend,
  output logic [IDW-1:0] q_fwd,
  output logic [IDW-1:0] q_bck
);
  localparam int NC = 3;

  logic [1:0] rst_sync;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  logic                   accept, busy, wr_en, nx_pend, cur_pend;
  logic [1:0]             cur_st, nx_st;
  logic [IDW-1:0]         cur_f, cur_b, nx_f, nx_b;
  logic [NC-1:0]          c_v;
  logic [NC-1:0][2:0]     c_kind;
  logic [NC-1:0][IDW-1:0] c_dst, c_ptr;

  assign in_ready = !busy;
  assign accept   = msg_valid && in_ready;

  sln_line_store #(.NLINES(NLINES), .IDW(IDW), .LW(LW)) store_i (
    .clk(clk), .rst_ni(rst_q),
    .we(wr_en), .wr_line(msg_line), .wr_st(nx_st), .wr_pend(nx_pend), .wr_f(nx_f), .wr_b(nx_b),
    .ra_line(msg_line), .ra_st(cur_st), .ra_pend(cur_pend), .ra_f(cur_f), .ra_b(cur_b),
    .rb_line(q_line), .rb_st(q_state), .rb_pend(q_pend), .rb_f(q_fwd), .rb_b(q_bck)
  );

  sln_decode #(.IDW(IDW), .MY_ID(MY_ID)) dec_i (
    .in_valid(accept), .in_kind(msg_kind), .in_src(msg_src), .in_ptr(msg_ptr),
    .cur_st(cur_st), .cur_pend(cur_pend), .cur_f(cur_f), .cur_b(cur_b),
    .wr_en(wr_en), .nx_st(nx_st), .nx_pend(nx_pend), .nx_f(nx_f), .nx_b(nx_b),
    .c_v(c_v), .c_kind(c_kind), .c_dst(c_dst), .c_ptr(c_ptr)
  );

  sln_outq #(.IDW(IDW), .LW(LW), .NC(NC)) q_i (
    .clk(clk), .rst_ni(rst_q), .load(accept), .ld_line(msg_line),
    .c_v(c_v), .c_kind(c_kind), .c_dst(c_dst), .c_ptr(c_ptr),
    .busy(busy), .o_valid(out_valid), .o_kind(out_kind), .o_dst(out_dst),
    .o_ptr(out_ptr), .o_line(out_line)
  );
endmodule

// File: rtl/sln_checks.sv
module sln_checks #(
  parameter int IDW   = 4,
  parameter int MY_ID = 3
) (
  input logic           clk,
  input logic           rst_q,
  input logic           msg_valid,
  input logic           in_ready,
  input logic [2:0]     msg_kind,
  input logic [IDW-1:0] msg_src,
  input logic [IDW-1:0] msg_ptr,
  input logic           out_valid,
  input logic [2:0]     out_kind,
  input logic [IDW-1:0] out_dst,
  input logic [IDW-1:0] out_ptr
);
  localparam logic [IDW-1:0] NULLID = '1;
  logic acc;
  assign acc = msg_valid && in_ready;

  a_r11_hold_ready: assert property (@(posedge clk) disable iff (!rst_q)
    msg_valid |-> in_ready);

  a_r11_no_null_dst: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid |-> (out_dst != NULLID));

  a_r6_ack_reply: assert property (@(posedge clk) disable iff (!rst_q)
    (acc && msg_kind == 3'd6 && msg_src != NULLID) |=>
      (out_valid && out_kind == 3'd7 && out_dst == $past(msg_src)));

  a_r3_insert_sent: assert property (@(posedge clk) disable iff (!rst_q)
    (acc && msg_kind == 3'd0 && msg_ptr != NULLID) |=>
      (out_valid && out_kind == 3'd3 && out_dst == $past(msg_ptr) && out_ptr == IDW'(MY_ID)));

  a_r2_silent_fill: assert property (@(posedge clk) disable iff (!rst_q)
    (acc && msg_kind == 3'd0 && msg_ptr == NULLID) |=> !out_valid);
endmodule

bind share_list_node sln_checks #(.IDW(IDW), .MY_ID(MY_ID)) chk_i (
  .clk(clk), .rst_q(rst_q), .msg_valid(msg_valid), .in_ready(in_ready),
  .msg_kind(msg_kind), .msg_src(msg_src), .msg_ptr(msg_ptr),
  .out_valid(out_valid), .out_kind(out_kind), .out_dst(out_dst), .out_ptr(out_ptr)
);

// File: tb/share_list_node_tb_top.sv
module share_list_node_tb_top;
  localparam int NLINES = 4;
  localparam int IDW    = 4;
  localparam int MY_ID  = 3;
  localparam int LW     = 2;
  localparam logic [3:0] NUL = 4'hF;

  logic clk, rst_n, msg_valid, in_ready, out_valid, q_pend;
  logic [2:0] msg_kind, out_kind;
  logic [LW-1:0] msg_line, out_line, q_line;
  logic [IDW-1:0] msg_src, msg_ptr, out_dst, out_ptr, q_fwd, q_bck;
  logic [1:0] q_state;

  int n_chk = 0;
  int n_fail = 0;
  logic [2:0] ok_k [4];
  logic [3:0] ok_d [4];
  logic [3:0] ok_p [4];
  int n_out;

  share_list_node #(.NLINES(NLINES), .IDW(IDW), .MY_ID(MY_ID)) dut_i (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .in_ready(in_ready),
    .msg_kind(msg_kind), .msg_line(msg_line), .msg_src(msg_src), .msg_ptr(msg_ptr),
    .out_valid(out_valid), .out_kind(out_kind), .out_dst(out_dst), .out_ptr(out_ptr),
    .out_line(out_line), .q_line(q_line), .q_state(q_state), .q_pend(q_pend),
    .q_fwd(q_fwd), .q_bck(q_bck)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // fields: req(4) kind(3) line(2) src(4) ptr(4) st(2) pend(1) fwd(4) bck(4) nout(2)
  localparam logic [29:0] TBL [16] = '{
    {4'd2,  3'd0, 2'd0, 4'd0,  4'd15, 2'd2, 1'b0, 4'd15, 4'd15, 2'd0}, // R2
    {4'd4,  3'd3, 2'd0, 4'd5,  4'd0,  2'd1, 1'b0, 4'd15, 4'd5,  2'd0}, // R4 E->S
    {4'd5,  3'd4, 2'd0, 4'd0,  4'd9,  2'd1, 1'b0, 4'd9,  4'd5,  2'd0}, // R5 fwd
    {4'd5,  3'd5, 2'd0, 4'd0,  4'd7,  2'd1, 1'b0, 4'd9,  4'd7,  2'd0}, // R5 bck
    {4'd4,  3'd3, 2'd1, 4'd6,  4'd0,  2'd0, 1'b0, 4'd15, 4'd15, 2'd0}, // R4 ignored
    {4'd5,  3'd4, 2'd1, 4'd0,  4'd2,  2'd0, 1'b0, 4'd15, 4'd15, 2'd0}, // R5 ignored
    {4'd3,  3'd0, 2'd1, 4'd0,  4'd8,  2'd1, 1'b0, 4'd8,  4'd15, 2'd1}, // R3
    {4'd8,  3'd7, 2'd1, 4'd0,  4'd4,  2'd1, 1'b0, 4'd8,  4'd15, 2'd0}, // R8 ignored
    {4'd6,  3'd6, 2'd1, 4'd10, 4'd0,  2'd0, 1'b0, 4'd15, 4'd15, 2'd1}, // R6
    {4'd12, 3'd1, 2'd2, 4'd0,  4'd15, 2'd3, 1'b0, 4'd15, 4'd15, 2'd0}, // R12
    {4'd4,  3'd3, 2'd2, 4'd12, 4'd0,  2'd1, 1'b0, 4'd15, 4'd12, 2'd0}, // R4 M->S
    {4'd10, 3'd2, 2'd2, 4'd0,  4'd0,  2'd0, 1'b0, 4'd15, 4'd15, 2'd1}, // R10
    {4'd7,  3'd1, 2'd3, 4'd0,  4'd5,  2'd1, 1'b1, 4'd5,  4'd15, 2'd1}, // R7
    {4'd8,  3'd7, 2'd3, 4'd0,  4'd6,  2'd1, 1'b1, 4'd6,  4'd15, 2'd1}, // R8 continue
    {4'd8,  3'd7, 2'd3, 4'd0,  4'd15, 2'd3, 1'b0, 4'd15, 4'd15, 2'd0}, // R8 done
    {4'd6,  3'd6, 2'd2, 4'd9,  4'd0,  2'd0, 1'b0, 4'd15, 4'd15, 2'd1}  // R6 invalid line
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] k, input logic [1:0] ln,
                      input logic [3:0] s, input logic [3:0] p);
    @(negedge clk);
    msg_valid = 1'b1; msg_kind = k; msg_line = ln; msg_src = s; msg_ptr = p;
    @(posedge clk);
    @(negedge clk);
    msg_valid = 1'b0;
    n_out = 0;
    while (!in_ready) begin
      if (n_out < 4) begin
        ok_k[n_out] = out_kind; ok_d[n_out] = out_dst; ok_p[n_out] = out_ptr;
      end
      chk(out_valid && out_dst != NUL, "R11 gapless/non-null", int'(out_dst), 0);
      n_out++;
      @(negedge clk);
    end
    chk(!out_valid, "R11 idle after drain", int'(out_valid), 0);
  endtask

  task automatic look(input logic [1:0] ln, input logic [1:0] st, input logic pd,
                      input logic [3:0] f, input logic [3:0] b, input string req);
    q_line = ln;
    #0.1;
    chk(q_state == st, req, int'(q_state), int'(st));
    chk(q_pend == pd, req, int'(q_pend), int'(pd));
    chk(q_fwd == f, req, int'(q_fwd), int'(f));
    chk(q_bck == b, req, int'(q_bck), int'(b));
  endtask

  task automatic out_is(input int i, input logic [2:0] k, input logic [3:0] d,
                        input logic [3:0] p, input string req);
    chk(ok_k[i] == k, req, int'(ok_k[i]), int'(k));
    chk(ok_d[i] == d, req, int'(ok_d[i]), int'(d));
    chk(ok_p[i] == p, req, int'(ok_p[i]), int'(p));
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; msg_valid = 1'b0; msg_kind = '0; msg_line = '0;
    msg_src = '0; msg_ptr = '0; q_line = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    for (int l = 0; l < NLINES; l++) look(2'(l), 2'd0, 1'b0, NUL, NUL, "R1");

    // table walk
    for (int r = 0; r < 16; r++) begin
      logic [29:0] e;
      string tag;
      e = TBL[r];
      tag = $sformatf("R%0d row%0d", e[29:26], r);
      send(e[25:23], e[22:21], e[20:17], e[16:13]);
      chk(n_out == int'(e[1:0]), tag, n_out, int'(e[1:0]));
      look(e[22:21], e[12:11], e[10], e[9:6], e[5:2], tag);
    end

    // R6: ack carries the former forward pointer (line0 is S fwd9 bck7)
    send(3'd6, 2'd0, 4'd11, 4'd0);
    out_is(0, 3'd7, 4'd11, 4'd9, "R6 ack content");

    // R3: insert content
    send(3'd0, 2'd0, 4'd0, 4'd8);
    chk(n_out == 1, "R3 count", n_out, 1);
    out_is(0, 3'd3, 4'd8, 4'd3, "R3 insert content");
    send(3'd3, 2'd0, 4'd4, 4'd0);

    // R9: mid-list write fill, home head = node 4
    send(3'd1, 2'd0, 4'd0, 4'd4);
    chk(n_out == 3, "R9 count", n_out, 3);
    out_is(0, 3'd4, 4'd4, 4'd8, "R9 set-fwd");
    out_is(1, 3'd5, 4'd8, 4'd4, "R9 set-bck");
    out_is(2, 3'd6, 4'd4, 4'd3, "R9 inval");
    look(2'd0, 2'd1, 1'b1, 4'd4, NUL, "R9 state");

    // R8: walk continues then ends
    send(3'd7, 2'd0, 4'd4, 4'd8);
    out_is(0, 3'd6, 4'd8, 4'd3, "R8 next inval");
    send(3'd7, 2'd0, 4'd8, NUL);
    chk(n_out == 0, "R8 end count", n_out, 0);
    look(2'd0, 2'd3, 1'b0, NUL, NUL, "R8 modified");

    // R9: write fill while already head (home head = own ID)
    send(3'd0, 2'd1, 4'd0, 4'd6);
    send(3'd1, 2'd1, 4'd0, 4'd3);
    chk(n_out == 2, "R9 head count", n_out, 2);
    out_is(0, 3'd5, 4'd6, NUL, "R9 head set-bck");
    out_is(1, 3'd6, 4'd6, 4'd3, "R9 head inval");
    look(2'd1, 2'd1, 1'b1, 4'd6, NUL, "R9 head state");

    // R1: reset mid-run clears lines
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    look(2'd0, 2'd0, 1'b0, NUL, NUL, "R1 re-reset");
    look(2'd1, 2'd0, 1'b0, NUL, NUL, "R1 re-reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule